// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block runs single external memory cycles for a small 8-bit controller. Its shared low port carries the low address byte first and then the data. A separate high port carries the upper address byte. The core presents a code fetch, an external data read or an external data write. The block then steps through a fixed phase sequence. It pulses an address-latch strobe so that an outside latch can hold the low byte. It then asserts exactly one read or write strobe. For reads, it captures the returned byte and hands it back with a one-cycle valid pulse.

Code fetches use a program-store strobe, and data reads use a separate read strobe. The two can be ANDed outside the chip so that one memory can serve both spaces. A data access may carry a full 16-bit address. It may instead carry a one-byte address, with a few high-port lines held as a page number. Leaving reset, the block issues a code fetch at address 0000H on its own.

The sequencer has six states: IDLE, ADDR, LATCH, STROBE, SAMPLE and RELEASE. The transitions are IDLE to ADDR on an accepted request, then ADDR to LATCH, LATCH to STROBE, STROBE to SAMPLE, SAMPLE to RELEASE and RELEASE back to IDLE. Each of these steps takes one clock, with no condition. Reset places the sequencer in ADDR with a fetch of address 0000H loaded.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block performs a code fetch at address 0000H without any request. It starts in ADDR with the low port and the high port both at 0, and returns the fetched byte with rdata_valid and rdata_code both 1.
- R2: A request is accepted only on a clock edge where req_valid is 1 and busy is 0. busy is then 1 for exactly the five cycles ADDR, LATCH, STROBE, SAMPLE and RELEASE. A request presented while busy is 1 is dropped and leaves no trace.
- R3: In ADDR, ale_n is 0, ad_oe is 1 and ad_out equals the low address byte. In LATCH, ale_n is 1 and the low byte is still driven. For a fetch, hi_addr is always req_addr[15:8], even when req_paged is 1.
- R4: For a fetch (req_kind 2'b00), psen_n is 0 in STROBE and SAMPLE only. ad_in is captured at the clock edge that ends SAMPLE. In RELEASE the captured byte appears on rdata, with rdata_valid 1 for that one cycle and rdata_code 1.
- R5: For a data read (req_kind 2'b01), rd_n is 0 in STROBE and SAMPLE while psen_n stays 1. The captured byte appears in RELEASE with rdata_valid 1 and rdata_code 0.
- R6: For a data write (req_kind 2'b10), wr_n is 0 in STROBE and SAMPLE. In those phases ad_out carries req_wdata with ad_oe 1. RELEASE has ad_oe 0, and no rdata_valid pulse occurs.
- R7: For a data access with req_paged 1, hi_addr equals req_page zero-extended to 8 bits, so req_addr[15:8] is ignored. The low byte still comes from req_addr[7:0], and the value is held for the whole cycle.
- R8: At most one of psen_n, rd_n and wr_n is 0 at any time, and all three are 1 while ale_n is 0.
- R9: req_kind 2'b11 is not accepted. busy stays 0, and every strobe stays 1 with ad_oe 0.
- R10: Whenever psen_n or rd_n is 0, ad_oe is 0, which releases the shared port to the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 reserved |
| req_paged | input | 1 | Data access uses the one-byte form with a page number |
| req_addr | input | 16 | Program counter or data address |
| req_page | input | 3 | Page number for the one-byte form |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A cycle is in progress, so new requests are refused |
| rdata | output | 8 | Byte returned by the last read |
| rdata_valid | output | 1 | One-cycle pulse, rdata is new |
| rdata_code | output | 1 | The returned byte came from a code fetch |
| ad_out | output | 8 | Shared port output: low address, then write data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input from memory |
| hi_addr | output | 8 | High address or page lines |
| ale_n | output | 1 | Address latch strobe, active low (latch transparent while 0) |
| psen_n | output | 1 | Program memory read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench holds a request asserted through a whole fetch. A design that accepted it would start a second cycle or write to memory, and the bench reads that location back. It issues a fetch with req_paged set and a paged write whose req_addr high byte is nonzero, so a design that mixed up the two address forms would show the wrong hi_addr. It also reads one bus location once by page and once by full address, which catches a page that is not zero-extended. The reserved request kind and the boot fetch out of reset are each checked phase by phase. A monitor flags any overlap of strobes at every cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_LATCH,
        PH_STROBE,
        PH_SAMPLE,
        PH_RELEASE
    } phase_t;

    typedef enum logic [1:0] {
        OP_FETCH  = 2'b00,
        OP_DREAD  = 2'b01,
        OP_DWRITE = 2'b10,
        OP_RSVD   = 2'b11
    } op_t;

endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       accept,
    output logic       busy,
    output logic       is_code,
    output logic       ale_n,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       drive_addr,
    output logic       drive_data,
    output logic       sample_en
);

    phase_t phase, phase_nx;
    op_t    op_q;

    assign accept  = (phase == PH_IDLE) && req_valid && (op_t'(req_kind) != OP_RSVD);
    assign busy    = (phase != PH_IDLE);
    assign is_code = (op_q == OP_FETCH);

    // state register; reset loads the boot fetch at 0000H
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_ADDR;
            op_q  <= OP_FETCH;
        end else begin
            phase <= phase_nx;
            if (accept) op_q <= op_t'(req_kind);
        end
    end

    always_comb begin
        phase_nx = PH_IDLE;
        unique case (phase)
            PH_IDLE:    phase_nx = accept ? PH_ADDR : PH_IDLE;
            PH_ADDR:    phase_nx = PH_LATCH;
            PH_LATCH:   phase_nx = PH_STROBE;
            PH_STROBE:  phase_nx = PH_SAMPLE;
            PH_SAMPLE:  phase_nx = PH_RELEASE;
            PH_RELEASE: phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        ale_n      = 1'b1;
        psen_n     = 1'b1;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        drive_addr = 1'b0;
        drive_data = 1'b0;
        sample_en  = 1'b0;
        unique case (phase)
            PH_ADDR: begin
                ale_n      = 1'b0;
                drive_addr = 1'b1;
            end
            PH_LATCH: begin
                drive_addr = 1'b1;
            end
            PH_STROBE, PH_SAMPLE: begin
                psen_n     = !(op_q == OP_FETCH);
                rd_n       = !(op_q == OP_DREAD);
                wr_n       = !(op_q == OP_DWRITE);
                drive_data = (op_q == OP_DWRITE);
                sample_en  = (phase == PH_SAMPLE) && (op_q != OP_DWRITE);
            end
            default: ;
        endcase
    end

    // R8: strobes never overlap
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!psen_n, !rd_n, !wr_n}));

    // R8: no read or write strobe while the address is being latched
    p_latch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_n |-> (psen_n && rd_n && wr_n));

    // R4: program strobe falls only right after the latch phase
    p_psen_after_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> ($past(phase) == PH_LATCH));

    // R2: a cycle always ends through the release phase
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(phase) == PH_RELEASE));

endmodule

// File: rtl/xmem_req_latch.sv
module xmem_req_latch
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic [1:0]        req_kind,
    input  logic              req_paged,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drive_addr,
    input  logic              drive_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_addr
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [DATA_W-1:0] wd_q;
    logic              use_page;

    assign use_page = req_paged && (op_t'(req_kind) != OP_FETCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            wd_q <= '0;
        end else if (accept) begin
            lo_q <= req_addr[DATA_W-1:0];
            hi_q <= use_page ? HI_W'(req_page) : req_addr[ADDR_W-1:DATA_W];
            wd_q <= req_wdata;
        end
    end

    assign ad_out  = drive_data ? wd_q : lo_q;
    assign ad_oe   = drive_addr || drive_data;
    assign hi_addr = hi_q;

    // R7: high lines hold their value through a cycle
    p_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(hi_addr));

endmodule

// File: rtl/xmem_rd_capture.sv
module xmem_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              is_code,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              rdata_code
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
            rdata_code  <= 1'b0;
        end else begin
            rdata_valid <= sample_en;
            if (sample_en) begin
                rdata      <= ad_in;
                rdata_code <= is_code;
            end
        end
    end

    // R4: valid is a single-cycle pulse
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic                     req_paged,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [PAGE_W-1:0]        req_page,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     busy,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic                     rdata_code,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_addr,
    output logic                     ale_n,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    logic accept, is_code, drive_addr, drive_data, sample_en;

    xmem_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .accept     (accept),
        .busy       (busy),
        .is_code    (is_code),
        .ale_n      (ale_n),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .sample_en  (sample_en)
    );

    xmem_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .busy       (busy),
        .req_kind   (req_kind),
        .req_paged  (req_paged),
        .req_addr   (req_addr),
        .req_page   (req_page),
        .req_wdata  (req_wdata),
        .drive_addr (drive_addr),
        .drive_data (drive_data),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .hi_addr    (hi_addr)
    );

    xmem_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .is_code     (is_code),
        .ad_in       (ad_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid),
        .rdata_code  (rdata_code)
    );

    // R10: port released while memory drives it
    p_port_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);

    // R9: reserved kind never starts a cycle
    p_rsvd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_kind == 2'b11) |=> !busy);

endmodule

// File: tb/xmem_bus_ctrl_tb.sv
module xmem_bus_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_paged = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [2:0]  req_page = 3'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        busy, rdata_valid, rdata_code, ad_oe, ale_n, psen_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, ad_in, hi_addr;

    int checks = 0;
    int errors = 0;
    int overlap_err = 0;
    bit done = 1'b0;

    logic [7:0] lat = 8'h0;
    logic [7:0] dmem [logic [15:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bus_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_paged (req_paged), .req_addr (req_addr), .req_page (req_page),
        .req_wdata (req_wdata), .busy (busy), .rdata (rdata),
        .rdata_valid (rdata_valid), .rdata_code (rdata_code), .ad_out (ad_out),
        .ad_oe (ad_oe), .ad_in (ad_in), .hi_addr (hi_addr), .ale_n (ale_n),
        .psen_n (psen_n), .rd_n (rd_n), .wr_n (wr_n)
    );

    function automatic logic [7:0] code_of(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // external address latch, transparent while ale_n is low
    always @(ale_n or ad_out) if (!ale_n) lat = ad_out;

    // memory model answering on the shared port
    always @* begin
        if (!psen_n) ad_in = code_of({hi_addr, lat});
        else if (!rd_n) ad_in = dmem.exists({hi_addr, lat}) ? dmem[{hi_addr, lat}] : 8'hEE;
        else ad_in = 8'h00;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!wr_n && ad_oe) dmem[{hi_addr, lat}] = ad_out;
            if (((!psen_n) + (!rd_n) + (!wr_n)) > 1) overlap_err++;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // called while the DUT is in the address phase; walks the rest of the cycle
    task automatic follow(input logic [1:0] kind, input logic [7:0] lo, input logic [7:0] exp_hi,
                          input logic [7:0] wd, input logic [7:0] exp_rd, input string tg);
        chk({tg, " R3 addr ale_n"}, ale_n, 0);
        chk({tg, " R3 addr oe"}, ad_oe, 1);
        chk({tg, " R3 addr lo"}, ad_out, lo);
        chk({tg, " R3 addr hi"}, hi_addr, exp_hi);
        chk({tg, " R8 quiet strobes"}, {psen_n, rd_n, wr_n}, 3'b111);
        chk({tg, " R2 busy"}, busy, 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk({tg, " R3 latch ale_n"}, ale_n, 1);
        chk({tg, " R3 latch lo held"}, {ad_oe, ad_out}, {1'b1, lo});
        chk({tg, " R8 latch strobes"}, {psen_n, rd_n, wr_n}, 3'b111);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            chk({tg, " R4 R5 R6 strobe"}, {psen_n, rd_n, wr_n},
                {kind != 2'b00, kind != 2'b01, kind != 2'b10});
            chk({tg, " R10 R6 oe"}, ad_oe, kind == 2'b10);
            if (kind == 2'b10) chk({tg, " R6 wdata"}, ad_out, wd);
            chk({tg, " R7 hi held"}, hi_addr, exp_hi);
        end
        @(negedge clk);
        chk({tg, " R6 release"}, {ad_oe, psen_n, rd_n, wr_n}, 4'b0111);
        chk({tg, " R4 R6 valid"}, rdata_valid, kind != 2'b10);
        if (kind != 2'b10) begin
            chk({tg, " R4 R5 rdata"}, rdata, exp_rd);
            chk({tg, " R4 R5 code flag"}, rdata_code, kind == 2'b00);
        end
        chk({tg, " R2 busy release"}, busy, 1);
        @(negedge clk);
        chk({tg, " R2 idle"}, {busy, rdata_valid}, 2'b00);
    endtask

    task automatic run_op(input logic [1:0] kind, input logic paged, input logic [15:0] addr,
                          input logic [2:0] page, input logic [7:0] wd,
                          input logic [7:0] exp_hi, input logic [7:0] exp_rd, input string tg);
        req_valid = 1'b1; req_kind = kind; req_paged = paged;
        req_addr = addr; req_page = page; req_wdata = wd;
        @(negedge clk);
        follow(kind, addr[7:0], exp_hi, wd, exp_rd, tg);
    endtask

    task automatic t_boot;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset addr phase", {busy, ale_n, ad_out, hi_addr}, {1'b1, 1'b0, 8'h00, 8'h00});
        rst_n = 1'b1;
        #1;
        follow(2'b00, 8'h00, 8'h00, 8'h00, code_of(16'h0000), "R1 boot");
    endtask

    task automatic t_fetches;
        run_op(2'b00, 1'b0, 16'h1234, 3'h0, 8'h00, 8'h12, code_of(16'h1234), "R4 fetch 1234");
        run_op(2'b00, 1'b0, 16'hFFFF, 3'h0, 8'h00, 8'hFF, code_of(16'hFFFF), "R4 fetch FFFF");
        run_op(2'b00, 1'b1, 16'hC381, 3'h6, 8'h00, 8'hC3, code_of(16'hC381), "R3 fetch ignores paged");
    endtask

    task automatic t_data_full;
        run_op(2'b10, 1'b0, 16'hA55A, 3'h0, 8'h3C, 8'hA5, 8'h00, "R6 write A55A");
        run_op(2'b01, 1'b0, 16'hA55A, 3'h0, 8'h00, 8'hA5, 8'h3C, "R5 read A55A");
        run_op(2'b01, 1'b0, 16'h1111, 3'h0, 8'h00, 8'h11, 8'hEE, "R5 read blank");
    endtask

    task automatic t_data_paged;
        run_op(2'b10, 1'b1, 16'hFF21, 3'h5, 8'hC7, 8'h05, 8'h00, "R7 paged write");
        run_op(2'b01, 1'b1, 16'h9921, 3'h5, 8'h00, 8'h05, 8'hC7, "R7 paged read");
        run_op(2'b01, 1'b0, 16'h0521, 3'h0, 8'h00, 8'h05, 8'hC7, "R7 full-form alias");
    endtask

    task automatic t_reserved;
        req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h4242; req_wdata = 8'h11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 reserved idle", {busy, ale_n, psen_n, rd_n, wr_n, ad_oe}, 6'b011110);
        end
        req_valid = 1'b0;
        run_op(2'b01, 1'b0, 16'h4242, 3'h0, 8'h00, 8'h42, 8'hEE, "R9 reserved no write");
    endtask

    task automatic t_busy_ignore;
        req_valid = 1'b1; req_kind = 2'b00; req_paged = 1'b0; req_addr = 16'h0100;
        @(negedge clk);
        chk("R2 busy fetch start", {busy, ale_n}, 2'b10);
        req_kind = 2'b10; req_addr = 16'h7777; req_wdata = 8'h99;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 busy req no write", wr_n, 1);
            chk("R2 busy hi kept", hi_addr, 8'h01);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 busy fetch data", {rdata_valid, rdata}, {1'b1, code_of(16'h0100)});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 dropped request", {busy, wr_n, ale_n}, 3'b011);
        end
        run_op(2'b01, 1'b0, 16'h7777, 3'h0, 8'h00, 8'h77, 8'hEE, "R2 dropped not written");
    endtask

    initial begin
        t_boot();
        t_fetches();
        t_data_full();
        t_data_paged();
        t_reserved();
        t_busy_ignore();
        chk("R8 strobe overlap count", overlap_err[15:0], 16'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule